// File: doc/BRIEF.md
# Configuration Address/Data Port Decoder

This block sits between a processor's I/O slave bus and the configuration space of an expansion bus. Software writes a 32-bit selector word into an address port, then reads or writes a data port. While the enable bit of the selector is set, each data-port access becomes one configuration request that carries the bus, device, function and dword register number. The request goes out on a request/acknowledge interface. The processor's I/O strobe is held until the target completes. When the enable bit is clear, data-port accesses never reach the target.

The selector is a plain readable latch. Software probes for the mechanism by writing 0x80000000 and reading the same value back. Any access the block does not claim goes to the downstream I/O bus unchanged: other ports, and non-dword accesses to the address port.

Top module: `cfg_port_decoder`

## Requirements
- R1: After reset the selector register is zero, `cfg_req` is low and no configuration request is pending.
- R2: A write to the address port 0x0CF8 with all four byte enables set stores `io_wdata` in the selector, including bits 1:0. A read there with all byte enables set returns the stored value. Both complete with `io_ready` high in the same cycle as the strobe.
- R3: During a request, `cfg_bus` shows selector bits 23:16, `cfg_dev` bits 15:11, `cfg_fn` bits 10:8 and `cfg_reg` bits 7:2. Selector bits 1:0 do not reach the request. `cfg_type0` is high exactly when bits 23:16 are zero.
- R4: While selector bit 31 is 0, an access to the data port (0x0CFC–0x0CFF, any nonzero byte enables) completes with `io_ready` high in the same cycle and raises no `cfg_req`. A read returns 0xFFFFFFFF.
- R5: While selector bit 31 is 1, a data-port access raises `cfg_req` in the cycle after the strobe is first sampled. `cfg_req` stays high until the cycle in which `cfg_ack` is high. `io_ready` stays low through that time.
- R6: In the cycle after `cfg_ack`, `io_ready` is high for exactly one cycle. A read returns `cfg_rdata` if `cfg_hit` was high with the acknowledge, and 0xFFFFFFFF if it was low.
- R7: During a request, `cfg_be` equals `io_be`, `cfg_wdata` equals `io_wdata`, and `cfg_we` is high for a write and low for a read.
- R8: The block does not claim accesses to other ports, or accesses to 0x0CF8 without all four byte enables. For these, `dn_rd`, `dn_wr`, `dn_addr`, `dn_be` and `dn_wdata` follow the I/O inputs, and `io_ready`/`io_rdata` come from `dn_ready`/`dn_rdata`. The selector register is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_addr | input | 16 | I/O byte address |
| io_be | input | 4 | I/O byte enables |
| io_rd | input | 1 | I/O read strobe, held until `io_ready` |
| io_wr | input | 1 | I/O write strobe, held until `io_ready` |
| io_wdata | input | 32 | I/O write data |
| io_rdata | output | 32 | I/O read data, valid with `io_ready` |
| io_ready | output | 1 | Access complete |
| dn_addr | output | 16 | Downstream I/O address |
| dn_be | output | 4 | Downstream byte enables |
| dn_rd | output | 1 | Downstream read strobe |
| dn_wr | output | 1 | Downstream write strobe |
| dn_wdata | output | 32 | Downstream write data |
| dn_rdata | input | 32 | Downstream read data |
| dn_ready | input | 1 | Downstream completion |
| cfg_req | output | 1 | Configuration request pending |
| cfg_we | output | 1 | Request is a write |
| cfg_bus | output | 8 | Bus number |
| cfg_dev | output | 5 | Device number |
| cfg_fn | output | 3 | Function number |
| cfg_reg | output | 6 | Dword register number |
| cfg_type0 | output | 1 | Bus number is zero |
| cfg_be | output | 4 | Request byte enables |
| cfg_wdata | output | 32 | Request write data |
| cfg_ack | input | 1 | Target completion |
| cfg_hit | input | 1 | A device claimed the request |
| cfg_rdata | input | 32 | Target read data |

## Verification
The bench uses the default port parameters, 0x0CF8 and 0x0CFC. With these, the probe sequence and the sub-dword offsets 0x0CFD–0x0CFF can be reached with the exact values software uses. The bench varies the target's acknowledge delay from zero to several cycles. This covers the one-cycle shortest request and a request held over many cycles. The bench also covers both `cfg_hit` outcomes, selectors on bus zero and on a nonzero bus, and the enable bit cleared between accesses.

// File: rtl/cfg_port_decoder.sv
module cfg_port_decoder #(
  parameter logic [15:0] ADDR_PORT = 16'h0CF8,
  parameter logic [15:0] DATA_PORT = 16'h0CFC
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] io_addr,
  input  logic [3:0]  io_be,
  input  logic        io_rd,
  input  logic        io_wr,
  input  logic [31:0] io_wdata,
  output logic [31:0] io_rdata,
  output logic        io_ready,
  output logic [15:0] dn_addr,
  output logic [3:0]  dn_be,
  output logic        dn_rd,
  output logic        dn_wr,
  output logic [31:0] dn_wdata,
  input  logic [31:0] dn_rdata,
  input  logic        dn_ready,
  output logic        cfg_req,
  output logic        cfg_we,
  output logic [7:0]  cfg_bus,
  output logic [4:0]  cfg_dev,
  output logic [2:0]  cfg_fn,
  output logic [5:0]  cfg_reg,
  output logic        cfg_type0,
  output logic [3:0]  cfg_be,
  output logic [31:0] cfg_wdata,
  input  logic        cfg_ack,
  input  logic        cfg_hit,
  input  logic [31:0] cfg_rdata
);
  localparam logic [31:0] ALL_ONES = '1;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_DONE} state_t;

  state_t      state;
  logic [31:0] sel_q;
  logic [31:0] resp_q;

  wire strobe   = io_rd | io_wr;
  wire hit_addr = (io_addr[15:2] == ADDR_PORT[15:2]) && (io_be == 4'hF);
  wire hit_data = (io_addr[15:2] == DATA_PORT[15:2]) && (io_be != 4'h0);
  wire claimed  = hit_addr | hit_data;
  wire enabled  = sel_q[31];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      sel_q  <= '0;
      resp_q <= '0;
    end else begin
      if (hit_addr && io_wr) sel_q <= io_wdata;
      case (state)
        S_IDLE: if (hit_data && strobe && enabled) state <= S_WAIT;
        S_WAIT: if (cfg_ack) begin
          state  <= S_DONE;
          resp_q <= cfg_hit ? cfg_rdata : ALL_ONES;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign cfg_req   = (state == S_WAIT);
  assign cfg_we    = io_wr;
  assign cfg_bus   = sel_q[23:16];
  assign cfg_dev   = sel_q[15:11];
  assign cfg_fn    = sel_q[10:8];
  assign cfg_reg   = sel_q[7:2];
  assign cfg_type0 = (sel_q[23:16] == 8'h00);
  assign cfg_be    = io_be;
  assign cfg_wdata = io_wdata;

  assign dn_addr  = io_addr;
  assign dn_be    = io_be;
  assign dn_wdata = io_wdata;
  assign dn_rd    = io_rd & ~claimed;
  assign dn_wr    = io_wr & ~claimed;

  assign io_ready = claimed
      ? strobe & (hit_addr | (state == S_DONE) | ((state == S_IDLE) & ~enabled))
      : dn_ready;
  assign io_rdata = hit_addr ? sel_q
                  : hit_data ? ((state == S_DONE) ? resp_q : ALL_ONES)
                  : dn_rdata;

  assert_reset_idle_R1: assert property (@(posedge clk) $rose(rst_n) |-> !cfg_req);

  assert_no_req_disabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_data && strobe && !enabled && !cfg_req) |=> !cfg_req);

  assert_req_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req && !cfg_ack) |=> cfg_req);

  assert_no_early_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |-> !io_ready);

  assert_ready_after_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req && cfg_ack && strobe) |=> io_ready);

  assert_ones_on_miss_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req && cfg_ack && !cfg_hit && io_rd) |=> (io_rdata == ALL_ONES));

  assert_forward_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_rd || dn_wr) |-> !cfg_req);
endmodule

// File: tb/sim_cfg_port_decoder.sv
module sim_cfg_port_decoder;
  logic        clk = 0, rst_n = 0;
  logic [15:0] io_addr = 0;
  logic [3:0]  io_be = 0;
  logic        io_rd = 0, io_wr = 0;
  logic [31:0] io_wdata = 0, dn_rdata = 32'h5A5A_0000;
  logic        dn_ready = 0, cfg_ack = 0, cfg_hit = 0;
  logic [31:0] cfg_rdata = 0;
  logic [31:0] io_rdata, dn_wdata, cfg_wdata;
  logic        io_ready, dn_rd, dn_wr, cfg_req, cfg_we, cfg_type0;
  logic [15:0] dn_addr;
  logic [3:0]  dn_be, cfg_be;
  logic [7:0]  cfg_bus;
  logic [4:0]  cfg_dev;
  logic [2:0]  cfg_fn;
  logic [5:0]  cfg_reg;

  cfg_port_decoder u0 (.*);

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  logic [31:0] m_sel = 0, m_resp = 0;
  int m_ph = 0;

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #9;
    if (rst_n) begin
      automatic bit strb = io_rd | io_wr;
      automatic bit ca = (io_addr[15:2] == 14'h033E) && (io_be == 4'hF);
      automatic bit cd = (io_addr[15:2] == 14'h033F) && (io_be != 0);
      automatic bit er;
      automatic logic [31:0] ed;
      check(cfg_req == (m_ph == 1), "R5 cfg_req", {31'd0, cfg_req}, {31'd0, m_ph == 1});
      if (ca) begin er = strb; ed = m_sel; end
      else if (cd) begin
        er = strb && (m_ph == 2 || (m_ph == 0 && !m_sel[31]));
        ed = (m_ph == 2) ? m_resp : 32'hFFFF_FFFF;
      end else begin er = dn_ready; ed = dn_rdata; end
      check(io_ready == er, cd ? "R4/R5/R6 io_ready" : ca ? "R2 io_ready" : "R8 io_ready",
            {31'd0, io_ready}, {31'd0, er});
      if (er && io_rd)
        check(io_rdata == ed, cd ? "R4/R6 rdata" : ca ? "R2 rdata" : "R8 rdata", io_rdata, ed);
      check({dn_rd, dn_wr} == ({io_rd, io_wr} & {2{!(ca | cd)}}), "R8 dn strobes",
            {30'd0, dn_rd, dn_wr}, {30'd0, io_rd & !(ca | cd), io_wr & !(ca | cd)});
      if (!(ca | cd) && strb)
        check(dn_addr == io_addr && dn_be == io_be && dn_wdata == io_wdata, "R8 dn fields",
              dn_wdata, io_wdata);
      if (cfg_req) begin
        check({cfg_bus, cfg_dev, cfg_fn, cfg_reg} == {m_sel[23:16], m_sel[15:11], m_sel[10:8], m_sel[7:2]},
              "R3 fields", {10'd0, cfg_bus, cfg_dev, cfg_fn, cfg_reg},
              {10'd0, m_sel[23:16], m_sel[15:11], m_sel[10:8], m_sel[7:2]});
        check(cfg_type0 == (m_sel[23:16] == 0), "R3 type0", {31'd0, cfg_type0}, {31'd0, m_sel[23:16] == 0});
        check(cfg_be == io_be && cfg_wdata == io_wdata && cfg_we == io_wr, "R7 pass", cfg_wdata, io_wdata);
      end
      if (ca && io_wr) m_sel = io_wdata;
      case (m_ph)
        0: if (cd && strb && m_sel[31]) m_ph = 1;
        1: if (cfg_ack) begin m_ph = 2; m_resp = cfg_hit ? cfg_rdata : 32'hFFFF_FFFF; end
        default: m_ph = 0;
      endcase
    end
  end

  task automatic idle();
    @(negedge clk);
    io_rd = 0; io_wr = 0; io_be = 0; io_addr = 0; cfg_ack = 0; dn_ready = 0;
  endtask

  task automatic sel_acc(bit wr, logic [15:0] a, logic [3:0] be, logic [31:0] d, bit dr);
    @(negedge clk);
    io_addr = a; io_be = be; io_wdata = d; io_rd = !wr; io_wr = wr; dn_ready = dr;
    idle();
  endtask

  task automatic cfg_acc(bit wr, logic [1:0] off, logic [3:0] be, logic [31:0] d,
                         int dly, bit hit, logic [31:0] resp);
    @(negedge clk);
    io_addr = 16'h0CFC | off; io_be = be; io_wdata = d; io_rd = !wr; io_wr = wr;
    for (int k = 1; k <= dly + 2; k++) begin
      @(negedge clk);
      cfg_ack = (k == dly + 1); cfg_hit = hit; cfg_rdata = resp;
    end
    idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #9;
    check(cfg_req == 0 && io_ready == 0, "R1 reset outputs", {31'd0, cfg_req}, 0);
    rst_n = 1;
    sel_acc(0, 16'h0CF8, 4'hF, 0, 0);                       // R1 selector reads zero
    sel_acc(1, 16'h0CF8, 4'hF, 32'h8000_0000, 0);           // R2 probe
    sel_acc(0, 16'h0CF8, 4'hF, 0, 0);
    sel_acc(1, 16'h0CF8, 4'hF, 32'h0000_0003, 0);           // R2 low bits kept
    sel_acc(0, 16'h0CF8, 4'hF, 0, 0);
    sel_acc(0, 16'h0CFC, 4'hF, 0, 0);                       // R4 disabled read
    sel_acc(1, 16'h0CFE, 4'h4, 32'h1234, 0);                // R4 disabled write
    sel_acc(1, 16'h0CF8, 4'hF, 32'h8003_A90F, 0);           // R3 bus 3 dev 21 fn 1 reg 3, low bits set
    cfg_acc(0, 0, 4'hF, 0, 0, 1, 32'hCAFE_F00D);            // R5/R6 zero delay
    cfg_acc(1, 1, 4'h2, 32'hDEAD_BEEF, 4, 1, 0);            // R7 sub-dword write
    cfg_acc(0, 3, 4'h8, 0, 2, 0, 32'h1111_2222);            // R6 miss gives ones
    sel_acc(1, 16'h0CF8, 4'hF, 32'h8000_F8FC, 0);           // R3 bus zero
    cfg_acc(0, 0, 4'hF, 0, 6, 1, 32'h0BAD_CAFE);
    sel_acc(1, 16'h0CF8, 4'h3, 32'h0, 1);                   // R8 partial selector write forwarded
    sel_acc(0, 16'h0CF8, 4'hF, 0, 0);                       // R8 selector unchanged
    sel_acc(0, 16'h0080, 4'hF, 0, 1);                       // R8 other port
    sel_acc(1, 16'h0CF4, 4'hF, 32'h7777, 1);
    sel_acc(1, 16'h0CF8, 4'hF, 32'h0, 0);                   // R4 cleared again
    sel_acc(0, 16'h0CFD, 4'h2, 0, 0);
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule